// File: doc/BRIEF.md
# SPI Serial Clock Ratio Generator

This block makes the serial clock of an SPI master from the system clock without a second clock domain. It holds a registered SCK level and emits two one-cycle strobes that the shift engine uses as clock enables: a sample strobe in the cycle where SCK rises and a launch strobe in the cycle where SCK falls. The SCK period, counted in system cycles, is selected by a 4-bit code that does not encode the ratio directly. Codes 0 to 7 give even ratios and codes 8 to 15 give odd ratios. Two extra controls can stretch the period further: a divide-by-four enable, and a half-speed enable that is kept per channel and chosen by the active channel number.

The selected ratio is taken into a working copy while chip select is inactive. While chip select is active, a new setting is held back until the shift engine reports a byte boundary, and is then applied at the next falling SCK edge. As a result, no SCK phase is ever cut short.

Top module: `spi_sck_gen`

## Requirements
- R1: With divide-by-four and half-speed off, codes 0..7 give an SCK period of 16 - 2*code system cycles.
- R2: Codes 8..15 give a base ratio of 31 - 2*code. Ratio 1 (code 15) toggles SCK on every system cycle, so there is an edge strobe each cycle and the period is 2.
- R3: For a ratio N of at least 2, SCK is high for floor(N/2) cycles and low for the remaining N - floor(N/2) cycles of each period.
- R4: When quarter_en is 1, the ratio is multiplied by 4.
- R5: When the bit of half_speed indexed by chan_sel is 1, the ratio is doubled. The half_speed bits of other channels have no effect.
- R6: sample_pulse is high for exactly the cycle in which SCK rises, and launch_pulse for exactly the cycle in which SCK falls. The two are never high together.
- R7: While cs_active is 0 at a clock edge, SCK is low after that edge and neither strobe is high. After cs_active goes to 1, the first rise follows N - floor(N/2) edges later.
- R8: While cs_active stays 1, changes to div_code, quarter_en, half_speed and chan_sel are ignored until a byte_done pulse is seen. The new ratio then takes effect at the next falling SCK edge.
- R9: Synchronous reset drives SCK low and both strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | Chip select asserted; SCK runs only while high |
| div_code | input | 4 | Encoded division ratio code |
| quarter_en | input | 1 | Multiply ratio by 4 |
| half_speed | input | NUM_CH | Per-channel half-speed enables |
| chan_sel | input | CH_W | Active channel, selects a half_speed bit |
| byte_done | input | 1 | Byte boundary strobe from the shift engine |
| sck | output | 1 | Registered serial clock level (idle low) |
| launch_pulse | output | 1 | One-cycle strobe on the SCK falling edge |
| sample_pulse | output | 1 | One-cycle strobe on the SCK rising edge |

## Verification
The hardest case to reach from the ports is a ratio change in the middle of a running transfer. The old setting has to survive a changed code that arrives without a byte boundary, and the new setting must first appear on a full low phase after the next fall. The bench runs at ratio 16, changes the code, measures one unchanged period, and then pulses byte_done in the middle of the high phase. It then measures the low and high phases that follow the fall. The rest of the sweep goes through every code with every combination of quarter, half-speed vector and channel. It measures first-rise latency, high time and low time against values computed in the bench.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;

  localparam int CODE_W   = 4;
  localparam int BASE_W   = 5;
  localparam int EXTRA_SH = 3;  // up to x4 then x2

  // Non-linear code to base ratio: even ratios for low codes, odd for high
  function automatic logic [BASE_W-1:0] base_ratio(input logic [CODE_W-1:0] code);
    int r;
    if (code[CODE_W-1]) r = 31 - 2 * int'(code);
    else                r = 16 - 2 * int'(code);
    return BASE_W'(r);
  endfunction

endpackage

// File: rtl/sck_ratio_decode.sv
module sck_ratio_decode
  import sck_div_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int CH_W    = 1,
  parameter int RATIO_W = 8
) (
  input  logic [CODE_W-1:0]  div_code,
  input  logic               quarter_en,
  input  logic [NUM_CH-1:0]  half_speed,
  input  logic [CH_W-1:0]    chan_sel,
  output logic [RATIO_W-1:0] ratio
);

  logic [NUM_CH-1:0] half_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_half
      assign half_hit[gi] = half_speed[gi] && (chan_sel == CH_W'(gi));
    end
  endgenerate

  always_comb begin
    ratio = RATIO_W'(base_ratio(div_code));
    if (quarter_en) ratio = ratio << 2;
    if (|half_hit)  ratio = ratio << 1;
  end

endmodule

// File: rtl/sck_cfg_hold.sv
module sck_cfg_hold #(
  parameter int RATIO_W   = 8,
  parameter int RATIO_MAX = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               byte_done,
  input  logic               fall_now,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic [RATIO_W-1:0] ratio_cur
);

  logic pend;
  logic take_mid;

  assign take_mid = (pend || byte_done) && fall_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_cur <= RATIO_W'(RATIO_MAX);
      pend      <= 1'b0;
    end else if (!run) begin
      ratio_cur <= ratio_in;
      pend      <= 1'b0;
    end else if (take_mid) begin
      ratio_cur <= ratio_in;
      pend      <= 1'b0;
    end else if (byte_done) begin
      pend      <= 1'b1;
    end
  end

  AST_HOLD_WITHOUT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(pend) && !$past(byte_done)) |-> $stable(ratio_cur)); // R8

endmodule

// File: rtl/sck_phase_gen.sv
module sck_phase_gen #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio,
  output logic               fall_now,
  output logic               sck,
  output logic               launch_pulse,
  output logic               sample_pulse
);

  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] half_n;
  logic [RATIO_W-1:0] hi_len;
  logic [RATIO_W-1:0] lo_len;
  logic               rise_now;

  assign half_n   = ratio >> 1;
  assign hi_len   = (half_n == '0) ? RATIO_W'(1) : half_n;
  assign lo_len   = ratio - half_n;
  assign rise_now = run && !sck && (cnt >= lo_len - RATIO_W'(1));
  assign fall_now = run &&  sck && (cnt >= hi_len - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sck          <= 1'b0;
      cnt          <= '0;
      launch_pulse <= 1'b0;
      sample_pulse <= 1'b0;
    end else begin
      launch_pulse <= 1'b0;
      sample_pulse <= 1'b0;
      if (rise_now) begin
        sck          <= 1'b1;
        sample_pulse <= 1'b1;
        cnt          <= '0;
      end else if (fall_now) begin
        sck          <= 1'b0;
        launch_pulse <= 1'b1;
        cnt          <= '0;
      end else begin
        cnt <= cnt + RATIO_W'(1);
      end
    end
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(launch_pulse && sample_pulse)); // R6
  AST_SAMPLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |-> (sck && !$past(sck))); // R6
  AST_LAUNCH_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    launch_pulse |-> (!sck && $past(sck))); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sck && !launch_pulse && !sample_pulse)); // R7

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import sck_div_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_active,
  input  logic [3:0]        div_code,
  input  logic              quarter_en,
  input  logic [NUM_CH-1:0] half_speed,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic              byte_done,
  output logic              sck,
  output logic              launch_pulse,
  output logic              sample_pulse
);

  localparam int RATIO_W   = BASE_W + EXTRA_SH;
  localparam int RATIO_MAX = 16 << EXTRA_SH;

  logic [RATIO_W-1:0] ratio_sel;
  logic [RATIO_W-1:0] ratio_cur;
  logic               fall_now;

  sck_ratio_decode #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .RATIO_W(RATIO_W)
  ) u_decode (
    .div_code  (div_code),
    .quarter_en(quarter_en),
    .half_speed(half_speed),
    .chan_sel  (chan_sel),
    .ratio     (ratio_sel)
  );

  sck_cfg_hold #(
    .RATIO_W  (RATIO_W),
    .RATIO_MAX(RATIO_MAX)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .run      (cs_active),
    .byte_done(byte_done),
    .fall_now (fall_now),
    .ratio_in (ratio_sel),
    .ratio_cur(ratio_cur)
  );

  sck_phase_gen #(
    .RATIO_W(RATIO_W)
  ) u_phase (
    .clk         (clk),
    .rst         (rst),
    .run         (cs_active),
    .ratio       (ratio_cur),
    .fall_now    (fall_now),
    .sck         (sck),
    .launch_pulse(launch_pulse),
    .sample_pulse(sample_pulse)
  );

endmodule

// File: tb/tb_spi_sck_gen.sv
`timescale 1ns/1ps
module tb_spi_sck_gen;

  logic       clk = 1'b0;
  logic       rst;
  logic       cs_active;
  logic [3:0] div_code;
  logic       quarter_en;
  logic [1:0] half_speed;
  logic [0:0] chan_sel;
  logic       byte_done;
  logic       sck;
  logic       launch_pulse;
  logic       sample_pulse;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  spi_sck_gen #(.NUM_CH(2)) dut (
    .clk(clk), .rst(rst), .cs_active(cs_active), .div_code(div_code),
    .quarter_en(quarter_en), .half_speed(half_speed), .chan_sel(chan_sel),
    .byte_done(byte_done), .sck(sck), .launch_pulse(launch_pulse),
    .sample_pulse(sample_pulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // count clock edges until sck reaches lvl, sampling at negedges
  task automatic wait_level(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sck !== lvl && n < 1000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, h, l;
    rst = 1'b1; cs_active = 1'b1; div_code = 4'hF; quarter_en = 1'b0;
    half_speed = 2'b00; chan_sel = 1'b0; byte_done = 1'b0;
    repeat (4) @(negedge clk);
    // R9: reset state
    check(sck == 1'b0 && launch_pulse == 1'b0 && sample_pulse == 1'b0, "R9",
          {sck, launch_pulse, sample_pulse}, 0);
    cs_active = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Sweep every code, quarter, half vector and channel
    for (int code = 0; code < 16; code++) begin
      for (int q = 0; q < 2; q++) begin
        for (int hv = 0; hv < 4; hv++) begin
          for (int ch = 0; ch < 2; ch++) begin
            int base, nr, hexp, lexp;
            string tag;
            base = (code < 8) ? 16 - 2 * code : 31 - 2 * code;
            nr   = base * (q ? 4 : 1) * (hv[ch] ? 2 : 1);
            hexp = (nr / 2 == 0) ? 1 : nr / 2;
            lexp = nr - nr / 2;
            tag  = q ? "R4" : (hv != 0) ? "R5" : (code < 8) ? "R1" : "R2";
            cs_active = 1'b0; div_code = 4'(code); quarter_en = q[0];
            half_speed = 2'(hv); chan_sel = 1'(ch);
            repeat (2) @(negedge clk);
            // R7: idle with chip select inactive
            check(sck == 1'b0 && !launch_pulse && !sample_pulse, "R7", sck, 0);
            cs_active = 1'b1;
            wait_level(1'b1, n);
            check(n == lexp, "R7", n, lexp);
            check(sample_pulse && !launch_pulse, "R6", {sample_pulse, launch_pulse}, 2);
            wait_level(1'b0, h);
            check(h == hexp, "R3", h, hexp);
            check(launch_pulse && !sample_pulse, "R6", {launch_pulse, sample_pulse}, 2);
            wait_level(1'b1, l);
            check(l == lexp, "R3", l, lexp);
            check(h + l == hexp + lexp, tag, h + l, hexp + lexp);
          end
        end
      end
    end

    // R7: dropping chip select while SCK is high forces it low
    @(negedge clk);
    cs_active = 1'b0; div_code = 4'h0; quarter_en = 1'b0; half_speed = 2'b00;
    repeat (2) @(negedge clk);
    cs_active = 1'b1;
    wait_level(1'b1, n);
    cs_active = 1'b0;
    @(negedge clk);
    check(sck == 1'b0 && !launch_pulse, "R7", sck, 0);

    // R8: code change mid-transfer is held until a byte boundary
    repeat (2) @(negedge clk);
    cs_active = 1'b1;
    wait_level(1'b1, n);
    div_code = 4'h6;                  // ratio 4 once taken
    wait_level(1'b0, h);
    wait_level(1'b1, l);
    check(h == 8 && l == 8, "R8", h + l, 16);
    byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0;
    wait_level(1'b0, h);
    wait_level(1'b1, l);
    check(l == 2, "R8", l, 2);
    wait_level(1'b0, h);
    check(h == 2, "R8", h, 2);
    cs_active = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule